// File: doc/BRIEF.md
# Dual Streaming Sample Buffer with Interrupts

The block holds two independent byte queues, channel A and channel B, of 1024 entries each, behind a byte-wide register bus. A host fills them by writing bytes. A sample-rate tick takes one byte from each channel and presents it on a per-channel sample output. A shared interrupt line tells the host when a queue passes its midpoint, reaches its top, or runs dry.

Each channel keeps two sticky status bits, half and full/empty. A status register reports both channels at once and clears all four bits and the interrupt when it is read. The host can empty both queues with a flush control bit or by changing the 2-bit mode. Queueing and draining happen only in streaming mode, where the mode value is 1. In the other modes a write into the buffer window stores the byte at the address given, and the tick is ignored. While both queues stay empty in streaming mode, the block raises the empty interrupt again every 1024 ticks, so that a host driven by interrupts keeps being paced.

Address map: when bit 11 of the address is 0, bit 10 selects the channel (0 is A, 1 is B) and bits 9:0 give the buffer offset. When bit 11 is 1, bits 1:0 select a register: 0 is mode, 1 is control, 2 is status and 3 is the half-interrupt enable.

Top module: `dual_sample_fifo`

## Requirements
- R1: Each channel holds up to 1024 bytes in first-in first-out order, and its read and write positions wrap modulo 1024. A streaming write into a channel that already holds 1024 bytes is dropped.
- R2: After every accepted push or pop, the channel's half bit (status bit 0) is 1 when the count is 511 or less, and 0 otherwise.
- R3: The interrupt is raised when a push brings a channel's count to 512, or a pop brings it to 511, provided that channel's enable bit in register 3 is set (bit 0 for A, bit 1 for B). Both enable bits reset to 1.
- R4: A push that brings a channel's count to 1023 sets its full/empty bit (status bit 1) and raises the interrupt.
- R5: A pop that brings a channel's count to 0 sets its full/empty bit and raises the interrupt.
- R6: Reading register 2 returns channel A's status in bits 1:0 and channel B's status in bits 3:2, with the upper bits 0. The read clears all four status bits and lowers the interrupt, unless a new event happens in the same cycle.
- R7: When the mode is not 1, a write into the buffer window stores the byte at the addressed channel and offset without changing the count. A read of the buffer window returns the stored byte one cycle later.
- R8: Writing register 1 with bit 7 set, or writing register 0 with a value whose bits 1:0 differ from the current mode, empties both channels (positions, counts and status) and lowers the interrupt. Rewriting the same mode has no effect.
- R9: In mode 1, while both channels hold 0 bytes, each 1024th consecutive tick sets both status bits of both channels and raises the interrupt.
- R10: A tick that finds a channel empty sets that channel's sample output to 0x80 and leaves its queue unchanged.
- R11: In mode 1, each tick pops one byte from each non-empty channel and shows it on that channel's sample output from the next cycle. In any other mode the tick changes neither the queues nor the sample outputs.
- R12: After reset the mode is 0, both enables are 1, all status bits are 0, the interrupt is low and both sample outputs are 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Bus write strobe |
| re_i | input | 1 | Bus read strobe |
| addr_i | input | 12 | Bus byte address |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Read data, valid the cycle after re_i |
| tick_i | input | 1 | Sample-rate tick, one pop per channel |
| smp_a_o | output | 8 | Last byte taken from channel A |
| smp_b_o | output | 8 | Last byte taken from channel B |
| irq_o | output | 1 | Shared interrupt, level |

## Verification
The assertions assume that at most one of we_i and re_i is high in a cycle, since the bus carries a single byte access per cycle, and that the mode does not change in the same cycle as a buffer write. The stimulus issues one access per task call and returns the strobes low before the next call. Ticks are driven only between bus accesses or alongside them, never inside a mode change, so the push, pop and flush priorities that the checks rely on are the only ones exercised.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_HEN  = 2'd3;
  localparam logic [1:0] MODE_STREAM = 2'd1;
  localparam int         FLUSH_BIT   = 7;
  localparam logic [7:0] SILENCE     = 8'h80;

  typedef struct packed {
    logic full_empty;
    logic half;
  } chan_stat_t;
endpackage

// File: rtl/dsf_channel.sv
module dsf_channel
  import dsf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic          poke_i,
  input  logic [PW-1:0] poke_addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  input  logic          half_en_i,
  input  logic          stat_clr_i,
  input  logic          idle_set_i,
  input  logic [PW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] sample_o,
  output chan_stat_t    status_o,
  output logic          empty_o,
  output logic          event_o
);
  localparam int HALF = DEPTH / 2;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  chan_stat_t    stat_q, stat_nx;
  logic          push_ok, pop_ok, half_evt, fe_evt;

  assign push_ok = push_i && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign cnt_nx  = cnt_q + CW'(push_ok) - CW'(pop_ok);

  assign half_evt = half_en_i &&
                    ((push_ok && !pop_ok && cnt_nx == CW'(HALF)) ||
                     (pop_ok && !push_ok && cnt_nx == CW'(HALF - 1)));
  assign fe_evt   = (push_ok && !pop_ok && cnt_nx == CW'(DEPTH - 1)) ||
                    (pop_ok && !push_ok && cnt_nx == '0);
  assign event_o  = !clear_i && (half_evt || fe_evt || idle_set_i);

  always_comb begin
    stat_nx = stat_clr_i ? '0 : stat_q;
    if (push_ok || pop_ok) stat_nx.half = (cnt_nx <= CW'(HALF - 1));
    if (fe_evt) stat_nx.full_empty = 1'b1;
    if (idle_set_i) stat_nx = '{full_empty: 1'b1, half: 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      stat_q <= '0;
    end else if (clear_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + PW'(1);
      if (pop_ok)  rptr_q <= rptr_q + PW'(1);
      cnt_q  <= cnt_nx;
      stat_q <= stat_nx;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clear_i)     mem[wptr_q]      <= wdata_i;
    else if (poke_i && !clear_i) mem[poke_addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sample_o <= DW'(SILENCE);
    else if (pop_i && !clear_i) sample_o <= pop_ok ? mem[rptr_q] : DW'(SILENCE);
  end

  assign rdata_o  = mem[raddr_i];
  assign status_o = stat_q;
  assign empty_o  = (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R1
  AST_DROP_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && !clear_i && cnt_q == CW'(DEPTH) |=> cnt_q == CW'(DEPTH)); // R1
  AST_FULL_SETS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && !clear_i && cnt_q == CW'(DEPTH - 2) |=> status_o.full_empty); // R4
  AST_DRAIN_SETS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && !clear_i && cnt_q == CW'(1) |=> status_o.full_empty && empty_o); // R5
  AST_SILENCE_ON_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && !clear_i && cnt_q == '0 |=> sample_o == DW'(SILENCE) && $stable(rptr_q)); // R10
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> empty_o && status_o == '0); // R8
endmodule

// File: rtl/dsf_idle_timer.sv
module dsf_idle_timer #(
  parameter int TICKS = 1024,
  localparam int TW   = $clog2(TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic armed_i,
  input  logic tick_i,
  output logic fire_o
);
  logic [TW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == TW'(TICKS - 1));
  assign fire_o = !clear_i && armed_i && tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || !armed_i) cnt_q <= '0;
    else if (tick_i)             cnt_q <= last ? '0 : cnt_q + TW'(1);
  end

  AST_IDLE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> cnt_q == '0); // R9
  AST_IDLE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o); // R9
endmodule

// File: rtl/dual_sample_fifo.sv
module dual_sample_fifo
  import dsf_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int DW         = 8,
  parameter int IDLE_TICKS = 1024,
  localparam int PW        = $clog2(DEPTH),
  localparam int AW        = PW + 2,
  localparam int NCH       = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_i,
  output logic [DW-1:0] smp_a_o,
  output logic [DW-1:0] smp_b_o,
  output logic          irq_o
);
  logic          reg_sel, ch_sel, streaming, clear, stat_rd, idle_fire, all_empty;
  logic [1:0]    ridx;
  logic [PW-1:0] offset;
  logic [1:0]    mode_q;
  logic [NCH-1:0] hen_q, evt, empty;
  logic [DW-1:0] smp [NCH];
  logic [DW-1:0] rd_ch [NCH];
  chan_stat_t    stat [NCH];
  logic [DW-1:0] rd_nx;

  assign reg_sel   = addr_i[AW-1];
  assign ch_sel    = addr_i[AW-2];
  assign offset    = addr_i[PW-1:0];
  assign ridx      = addr_i[1:0];
  assign streaming = (mode_q == MODE_STREAM);
  assign stat_rd   = re_i && reg_sel && ridx == REG_STAT;
  assign clear     = we_i && reg_sel &&
                     ((ridx == REG_MODE && wdata_i[1:0] != mode_q) ||
                      (ridx == REG_CTRL && wdata_i[FLUSH_BIT]));
  assign all_empty = &empty;

  dsf_idle_timer #(.TICKS(IDLE_TICKS)) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .armed_i (streaming && all_empty),
    .tick_i  (tick_i),
    .fire_o  (idle_fire)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = we_i && !reg_sel && (ch_sel == 1'(c));
    dsf_channel #(.DEPTH(DEPTH), .DW(DW)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clear_i     (clear),
      .push_i      (sel && streaming),
      .poke_i      (sel && !streaming),
      .poke_addr_i (offset),
      .wdata_i     (wdata_i),
      .pop_i       (tick_i && streaming),
      .half_en_i   (hen_q[c]),
      .stat_clr_i  (stat_rd),
      .idle_set_i  (idle_fire),
      .raddr_i     (offset),
      .rdata_o     (rd_ch[c]),
      .sample_o    (smp[c]),
      .status_o    (stat[c]),
      .empty_o     (empty[c]),
      .event_o     (evt[c])
    );
  end

  assign smp_a_o = smp[0];
  assign smp_b_o = smp[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      hen_q  <= '1;
    end else if (we_i && reg_sel) begin
      if (ridx == REG_MODE) mode_q <= wdata_i[1:0];
      if (ridx == REG_HEN)  hen_q  <= wdata_i[NCH-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_o <= 1'b0;
    else if (clear)   irq_o <= 1'b0;
    else if (|evt)    irq_o <= 1'b1;
    else if (stat_rd) irq_o <= 1'b0;
  end

  always_comb begin
    rd_nx = rd_ch[ch_sel];
    if (reg_sel) begin
      unique case (ridx)
        REG_MODE: rd_nx = DW'(mode_q);
        REG_CTRL: rd_nx = '0;
        REG_STAT: rd_nx = DW'({stat[1], stat[0]});
        default:  rd_nx = DW'(hen_q);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_nx;
  end

  AST_STAT_READ_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd && !(|evt) |=> !irq_o); // R6
  AST_STAT_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd && !(|evt) && !tick_i && !we_i |=> stat[0] == '0 && stat[1] == '0); // R6
  AST_FLUSH_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> !irq_o && all_empty); // R8
  AST_EVENT_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> irq_o); // R3
  AST_IDLE_SETS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_fire |=> stat[0] == 2'b11 && stat[1] == 2'b11); // R9
  AST_NO_TICK_OUTSIDE_STREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !streaming |=> $stable(smp[0]) && $stable(smp[1])); // R11
endmodule

// File: tb/dual_sample_fifo_test.sv
module dual_sample_fifo_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0, re_i = 1'b0, tick_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o, smp_a_o, smp_b_o;
  logic        irq_o;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R12";

  always #2.5 clk_i = ~clk_i;

  dual_sample_fifo uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i),
    .smp_a_o(smp_a_o), .smp_b_o(smp_b_o), .irq_o(irq_o)
  );

  // behavioural reference
  logic [7:0] m_mem [2][1024];
  int   m_cnt [2], m_wp [2], m_rp [2];
  logic [1:0] m_st [2];
  logic [7:0] m_smp [2];
  logic [7:0] m_rd;
  logic [1:0] m_mode, m_hen;
  bit   m_irq, m_rdv;
  int   m_idle;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_wp[c] = 0; m_rp[c] = 0; m_st[c] = 0; m_smp[c] = 8'h80;
      end
      m_mode = 0; m_hen = 2'b11; m_irq = 0; m_idle = 0; m_rdv = 0; m_rd = 0;
    end else begin
      bit rsel, clr, stream, ev, armed, fire;
      int ridx, ch, off;
      rsel = addr_i[11]; ridx = int'(addr_i[1:0]); ch = int'(addr_i[10]); off = int'(addr_i[9:0]);
      m_rdv = re_i;
      if (re_i) begin
        if (rsel) begin
          case (ridx)
            0: m_rd = {6'd0, m_mode};
            1: m_rd = 0;
            2: m_rd = {4'd0, m_st[1], m_st[0]};
            default: m_rd = {6'd0, m_hen};
          endcase
        end else m_rd = m_mem[ch][off];
      end
      clr = we_i && rsel && ((ridx == 0 && wdata_i[1:0] != m_mode) || (ridx == 1 && wdata_i[7]));
      stream = (m_mode == 2'd1);
      if (we_i && rsel && ridx == 0) m_mode = wdata_i[1:0];
      if (we_i && rsel && ridx == 3) m_hen = wdata_i[1:0];
      if (clr) begin
        for (int c = 0; c < 2; c++) begin m_cnt[c] = 0; m_wp[c] = 0; m_rp[c] = 0; m_st[c] = 0; end
        m_idle = 0; m_irq = 0;
      end else begin
        if (re_i && rsel && ridx == 2) begin m_st[0] = 0; m_st[1] = 0; m_irq = 0; end
        ev = 0; fire = 0;
        armed = stream && m_cnt[0] == 0 && m_cnt[1] == 0;
        if (!armed) m_idle = 0;
        else if (tick_i) begin
          m_idle++;
          if (m_idle == 1024) begin m_idle = 0; fire = 1; end
        end
        for (int c = 0; c < 2; c++) begin
          bit push, poke, pop;
          int n;
          push = we_i && !rsel && ch == c && stream && m_cnt[c] < 1024;
          poke = we_i && !rsel && ch == c && !stream;
          pop  = tick_i && stream && m_cnt[c] > 0;
          if (tick_i && stream) m_smp[c] = pop ? m_mem[c][m_rp[c]] : 8'h80;
          if (push) begin m_mem[c][m_wp[c]] = wdata_i; m_wp[c] = (m_wp[c] + 1) % 1024; end
          if (poke) m_mem[c][off] = wdata_i;
          if (pop) m_rp[c] = (m_rp[c] + 1) % 1024;
          n = m_cnt[c] + int'(push) - int'(pop);
          if (push || pop) m_st[c][0] = (n <= 511);
          if (push && !pop) begin
            if (n == 512 && m_hen[c]) ev = 1;
            if (n == 1023) begin m_st[c][1] = 1; ev = 1; end
          end
          if (pop && !push) begin
            if (n == 511 && m_hen[c]) ev = 1;
            if (n == 0) begin m_st[c][1] = 1; ev = 1; end
          end
          m_cnt[c] = n;
        end
        if (fire) begin m_st[0] = 2'b11; m_st[1] = 2'b11; ev = 1; end
        if (ev) m_irq = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      cycles++;
      chk(smp_a_o == m_smp[0], "model sample A", smp_a_o, m_smp[0]);
      chk(smp_b_o == m_smp[1], "model sample B", smp_b_o, m_smp[1]);
      chk(irq_o == m_irq, "model irq", irq_o, m_irq);
      if (m_rdv) chk(rdata_o == m_rd, "model read data", rdata_o, m_rd);
      if (cycles > 150000) begin
        chk(0, "watchdog expired", cycles, 150000);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] v);
    re_i = 1; addr_i = a;
    @(negedge clk_i);
    re_i = 0;
    v = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1;
      @(negedge clk_i);
    end
    tick_i = 0;
  endtask

  task automatic push(input bit ch, input int n, input int seed, input int mul);
    for (int i = 0; i < n; i++) wr({1'b0, ch, 10'd0}, 8'((seed + i * mul) & 8'hff));
  endtask

  localparam logic [11:0] A_MODE = 12'h800, A_CTRL = 12'h801, A_STAT = 12'h802, A_HEN = 12'h803;

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    cur_req = "R12";
    rd(A_MODE, v); chk(v == 0, "reset mode", v, 0);
    rd(A_HEN, v);  chk(v == 3, "reset enables", v, 3);
    rd(A_STAT, v); chk(v == 0, "reset status", v, 0);
    chk(smp_a_o == 8'h80 && smp_b_o == 8'h80, "reset samples", smp_a_o, 8'h80);
    chk(irq_o == 0, "reset irq", irq_o, 0);

    cur_req = "R3";
    wr(A_MODE, 8'd1);
    push(0, 511, 8'h5A, 1);
    chk(irq_o == 0, "no irq below 512", irq_o, 0);
    push(0, 1, 8'h5A + 511, 1);
    chk(irq_o == 1, "irq on push to 512", irq_o, 1);
    cur_req = "R6";
    rd(A_STAT, v); chk(v == 8'h00, "status above half", v, 0);
    chk(irq_o == 0, "read lowers irq", irq_o, 0);

    cur_req = "R3";
    ticks(1);
    chk(irq_o == 1, "irq on pop to 511", irq_o, 1);
    cur_req = "R11";
    chk(smp_a_o == 8'h5A, "first popped byte", smp_a_o, 8'h5A);
    cur_req = "R10";
    chk(smp_b_o == 8'h80, "empty channel silence", smp_b_o, 8'h80);
    cur_req = "R2";
    rd(A_STAT, v); chk(v == 8'h01, "half bit after pop", v, 1);

    cur_req = "R5";
    ticks(511);
    chk(smp_a_o == 8'((8'h5A + 511) & 8'hff), "last byte A", smp_a_o, (8'h5A + 511) & 8'hff);
    rd(A_STAT, v); chk(v == 8'h03, "drain sets full/empty", v, 3);
    cur_req = "R10";
    ticks(1);
    chk(smp_a_o == 8'h80, "silence after drain", smp_a_o, 8'h80);

    cur_req = "R9";
    wr(A_CTRL, 8'h80);
    ticks(1023);
    chk(irq_o == 0, "no idle irq before 1024 ticks", irq_o, 0);
    ticks(1);
    chk(irq_o == 1, "idle irq at 1024 ticks", irq_o, 1);
    rd(A_STAT, v); chk(v == 8'h0F, "idle status all set", v, 8'h0F);

    cur_req = "R4";
    push(1, 1022, 7, 3);
    rd(A_STAT, v);
    chk(irq_o == 0, "irq cleared before full", irq_o, 0);
    push(1, 1, 7 + 1022 * 3, 3);
    chk(irq_o == 1, "irq on push to 1023", irq_o, 1);
    rd(A_STAT, v); chk(v == 8'h08, "full bit B", v, 8'h08);

    cur_req = "R1";
    push(1, 1, 7 + 1023 * 3, 3);
    wr(12'h400, 8'hEE);
    ticks(1024);
    chk(smp_b_o == 8'((7 + 1023 * 3) & 8'hff), "1024th byte kept", smp_b_o, (7 + 1023 * 3) & 8'hff);
    ticks(1);
    chk(smp_b_o == 8'h80, "dropped write not stored", smp_b_o, 8'h80);
    push(1, 10, 8'h31, 5);
    ticks(10);
    chk(smp_b_o == 8'((8'h31 + 45) & 8'hff), "wrapped positions", smp_b_o, (8'h31 + 45) & 8'hff);

    cur_req = "R3";
    wr(A_HEN, 8'h00);
    wr(A_CTRL, 8'h80);
    push(0, 512, 8'h11, 1);
    chk(irq_o == 0, "disabled half irq", irq_o, 0);
    wr(A_HEN, 8'h03);

    cur_req = "R8";
    wr(A_MODE, 8'd1);
    ticks(1);
    chk(smp_a_o == 8'h11, "same mode keeps data", smp_a_o, 8'h11);
    wr(A_CTRL, 8'h80);
    ticks(1);
    chk(smp_a_o == 8'h80, "flush empties", smp_a_o, 8'h80);
    push(0, 5, 8'h40, 1);
    ticks(1);
    chk(smp_a_o == 8'h40, "pop before mode change", smp_a_o, 8'h40);
    wr(A_MODE, 8'd2);
    chk(irq_o == 0, "mode change irq low", irq_o, 0);

    cur_req = "R11";
    ticks(3);
    chk(smp_a_o == 8'h40, "tick ignored in mode 2", smp_a_o, 8'h40);
    cur_req = "R8";
    wr(A_MODE, 8'd1);
    ticks(1);
    chk(smp_a_o == 8'h80, "mode change emptied queue", smp_a_o, 8'h80);

    cur_req = "R7";
    wr(A_MODE, 8'd0);
    wr(12'h123, 8'hC3);
    wr(12'h7FF, 8'h3C);
    rd(12'h123, v); chk(v == 8'hC3, "direct store A", v, 8'hC3);
    rd(12'h7FF, v); chk(v == 8'h3C, "direct store B", v, 8'h3C);
    rd(A_STAT, v);  chk(v == 8'h00, "direct store leaves status", v, 0);

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule